// File: doc/BRIEF.md
# Prioritized Cascadable Interrupt Controller

The block gathers up to 32 interrupt request lines into one request line for a processor. Each line is passed through a two-stage synchronizer and then recorded in a pending register. A build-time mask picks, for each line, whether a rising edge or a high level sets its pending bit. A per-line enable mask, a master enable and a nesting threshold together decide whether a pending bit may raise the processor request. Software reaches all state through a simple synchronous register port: a word address, write data, a write strobe, and read data that is combinational from the address.

Software services interrupts by reading the vector word, which returns the lowest-numbered source that is both pending and enabled, and then writing a one to that bit of the acknowledge word. For nested handling, the threshold word holds back the source being served and every lower-priority source. A control bit selects one of two modes. In the test mode, software may inject pending bits and the hardware lines are ignored. In the run mode, only the hardware lines count.

A role parameter lets several instances form a chain. In the primary and secondary roles, line 31 is taken from the request output of the next instance downstream and is always treated as a level source.

Top module: `irq_ctrl_top`

## Requirements
- R1: After reset the following hold: raw pending (word 0) reads 0, enable (word 2) reads 0, control (word 7) reads 0, threshold (word 8) reads all ones, vector (word 6) reads all ones, and `irq_out` is low.
- R2: Word 6 reads the index of the lowest-numbered bit of pending AND enable, with bit 0 the highest priority. It reads 32'hFFFFFFFF when no such bit exists. The threshold does not affect this word.
- R3: Writing to word 3 clears every pending bit whose data bit is 1 and leaves the other pending bits unchanged. If a new set event for a bit arrives in the same cycle as its acknowledge, the bit stays set.
- R4: Word 2 is read/write as a whole. Writing word 4 sets the enable bits given by ones in the data. Writing word 5 clears the enable bits given by ones in the data. Word 1 reads pending AND enable.
- R5: Control word 7 bit 0 is the master enable. While it is 0, `irq_out` stays low, one clock after the bit is written.
- R6: `irq_out` is registered. It rises one clock after a pending bit appears that is enabled and below the threshold. A hardware line that rises before clock edge 1 shows as pending after edge 3, because of the two synchronizer flops.
- R7: An edge line (EDGE_MASK bit 1) sets pending on a rising edge. The bit stays set after the line falls. A new rising edge after an acknowledge sets it again.
- R8: A level line (EDGE_MASK bit 0) holds pending set while the line is high, including across an acknowledge that is written while the line is high.
- R9: When threshold word 8 holds N, only sources with index below N can raise `irq_out`. Pending bits at or above N are still recorded.
- R10: Control bit 1 selects the mode: 0 is the test mode, 1 is the run mode. In the test mode the hardware lines never set pending, and writing word 9 sets the pending bits given by ones in the data. In the run mode, writes to word 9 have no effect.
- R11: In the primary or secondary role, pending bit 31 follows `cascade_in` as a level source and ignores `irq_in[31]`. In the none or last role, bit 31 comes from `irq_in[31]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | 32 | Asynchronous interrupt request lines |
| cascade_in | input | 1 | Request output of the downstream instance |
| addr | input | 4 | Register word address |
| wr_en | input | 1 | Write strobe |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` |
| irq_out | output | 1 | Registered request to the processor |

## Verification
The bench builds the block in the primary role with lines 0 to 15 as edge sources and lines 16 to 31 as level sources. This lets one instance cover the edge behaviour, the level behaviour and the chain link on line 31, where `irq_in[31]` must be ignored. Random passes in the test mode inject random pending patterns against random enables and thresholds, including threshold values of 0, 32 and above. These passes exercise the vector encoding and the request gating over far more bit combinations than directed steps alone would reach.

// File: rtl/irq_pkg.sv
// Shared types and register word offsets of the interrupt controller.
package irq_pkg;
    typedef enum logic [1:0] {
        ROLE_NONE      = 2'd0,
        ROLE_PRIMARY   = 2'd1,
        ROLE_SECONDARY = 2'd2,
        ROLE_LAST      = 2'd3
    } role_e;

    localparam int OFF_RAW    = 0;
    localparam int OFF_ACTIVE = 1;
    localparam int OFF_EN     = 2;
    localparam int OFF_ACK    = 3;
    localparam int OFF_EN_SET = 4;
    localparam int OFF_EN_CLR = 5;
    localparam int OFF_VECTOR = 6;
    localparam int OFF_CTRL   = 7;
    localparam int OFF_THRESH = 8;
    localparam int OFF_INJECT = 9;
endpackage

// File: rtl/irq_sync.sv
// Two-flop synchronizer per line, followed by a per-line event qualifier.
// The output is the rising edge for edge lines and the synchronized level
// for level lines. Assumes the raw lines are asynchronous to clk.
module irq_sync #(
    parameter int          W         = 32,
    parameter logic [W-1:0] EDGE_MASK = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw,
    output logic [W-1:0] evt
);
    logic [W-1:0] meta_q, sync_q, prev_q;

    // Two-stage synchronization plus one delayed copy for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= raw;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    for (genvar i = 0; i < W; i++) begin : g_line
        if (EDGE_MASK[i]) begin : g_edge
            assign evt[i] = sync_q[i] & ~prev_q[i];
        end else begin : g_level
            assign evt[i] = sync_q[i];
        end
    end
endmodule

// File: rtl/irq_pending.sv
// Pending register: a set event takes priority over an acknowledge in the
// same cycle, so an event close to the acknowledge is not lost.
module irq_pending #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_vec,
    input  logic [W-1:0] clr_vec,
    output logic [W-1:0] pend
);
    // Hold, clear on acknowledge, set on event.
    always_ff @(posedge clk) begin
        if (!rst_n) pend <= '0;
        else        pend <= (pend & ~clr_vec) | set_vec;
    end

    // R3: an acknowledged bit with no competing set is clear next cycle.
    a_r3_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend & $past(clr_vec & ~set_vec)) == '0));

    // R3: acknowledge never clears a bit that has a simultaneous set.
    a_r3_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend & $past(set_vec)) == $past(set_vec)));
endmodule

// File: rtl/irq_prio.sv
// Fixed-priority encoder: the lowest-numbered request bit wins.
module irq_prio #(
    parameter int W     = 32,
    parameter int IDX_W = $clog2(W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [W-1:0]     req,
    output logic             valid,
    output logic [IDX_W-1:0] idx
);
    // Scan from the lowest priority down so the lowest index is kept last.
    always_comb begin
        valid = 1'b0;
        idx   = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (req[i]) begin
                valid = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end

    // R2: the chosen bit is requested and no lower-numbered bit is.
    a_r2_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> (req[idx] && ((req & ((W'(1) << idx) - W'(1))) == '0)));

    // R2: no winner only when there is no request at all.
    a_r2_none_empty: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |-> (req == '0));
endmodule

// File: rtl/irq_ctrl_top.sv
// Interrupt controller top: register port, enable and threshold gating,
// master enable, test/run mode and chain link on the last line.
// Assumes a single writer on the register port; reads are combinational.
module irq_ctrl_top #(
    parameter int             NUM_SRC   = 32,
    parameter int             ADDR_W    = 4,
    parameter irq_pkg::role_e ROLE      = irq_pkg::ROLE_NONE,
    parameter logic [NUM_SRC-1:0] EDGE_MASK = '0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_in,
    input  logic               cascade_in,
    input  logic [ADDR_W-1:0]  addr,
    input  logic               wr_en,
    input  logic [NUM_SRC-1:0] wdata,
    output logic [NUM_SRC-1:0] rdata,
    output logic               irq_out
);
    import irq_pkg::*;

    localparam int  W       = NUM_SRC;
    localparam int  IDX_W   = $clog2(W);
    localparam bit  CHAINED = (ROLE == ROLE_PRIMARY) || (ROLE == ROLE_SECONDARY);
    localparam logic [W-1:0] EFF_EDGE = CHAINED ? {1'b0, EDGE_MASK[W-2:0]} : EDGE_MASK;

    logic [W-1:0]     en_q, thr_q, pend, hw_evt, raw, set_vec, clr_vec;
    logic [W-1:0]     thr_mask, active;
    logic             me_q, run_q, irq_q, vec_valid;
    logic [IDX_W-1:0] vec_idx;
    logic             wr_ack, wr_en_all, wr_en_set, wr_en_clr, wr_ctrl, wr_thr, wr_inj;

    assign wr_ack    = wr_en && (addr == ADDR_W'(OFF_ACK));
    assign wr_en_all = wr_en && (addr == ADDR_W'(OFF_EN));
    assign wr_en_set = wr_en && (addr == ADDR_W'(OFF_EN_SET));
    assign wr_en_clr = wr_en && (addr == ADDR_W'(OFF_EN_CLR));
    assign wr_ctrl   = wr_en && (addr == ADDR_W'(OFF_CTRL));
    assign wr_thr    = wr_en && (addr == ADDR_W'(OFF_THRESH));
    assign wr_inj    = wr_en && (addr == ADDR_W'(OFF_INJECT));

    // Line W-1 carries the downstream request in the chained roles.
    assign raw = {CHAINED ? cascade_in : irq_in[W-1], irq_in[W-2:0]};

    irq_sync #(.W(W), .EDGE_MASK(EFF_EDGE)) u_sync (
        .clk(clk), .rst_n(rst_n), .raw(raw), .evt(hw_evt)
    );

    // Hardware events count only in run mode; injection only in test mode.
    always_comb begin
        set_vec = run_q ? hw_evt : '0;
        if (wr_inj && !run_q) set_vec = set_vec | wdata;
        clr_vec = wr_ack ? wdata : '0;
    end

    irq_pending #(.W(W)) u_pend (
        .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_vec(clr_vec), .pend(pend)
    );

    // Enable mask with whole-word, set-bits and clear-bits writes.
    always_ff @(posedge clk) begin
        if (!rst_n)         en_q <= '0;
        else if (wr_en_all) en_q <= wdata;
        else if (wr_en_set) en_q <= en_q | wdata;
        else if (wr_en_clr) en_q <= en_q & ~wdata;
    end

    // Control bits and nesting threshold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            me_q  <= 1'b0;
            run_q <= 1'b0;
            thr_q <= '1;
        end else begin
            if (wr_ctrl) begin
                me_q  <= wdata[0];
                run_q <= wdata[1];
            end
            if (wr_thr) thr_q <= wdata;
        end
    end

    // Sources below the threshold value may raise the request.
    for (genvar i = 0; i < W; i++) begin : g_thr
        assign thr_mask[i] = (W'(i) < thr_q);
    end

    assign active = pend & en_q & thr_mask;

    // Registered processor request.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= me_q && (|active);
    end
    assign irq_out = irq_q;

    irq_prio #(.W(W), .IDX_W(IDX_W)) u_prio (
        .clk(clk), .rst_n(rst_n), .req(pend & en_q), .valid(vec_valid), .idx(vec_idx)
    );

    // Read multiplexer.
    always_comb begin
        case (int'(addr))
            OFF_RAW:    rdata = pend;
            OFF_ACTIVE: rdata = pend & en_q;
            OFF_EN:     rdata = en_q;
            OFF_VECTOR: rdata = vec_valid ? W'(vec_idx) : '1;
            OFF_CTRL:   rdata = {{(W-2){1'b0}}, run_q, me_q};
            OFF_THRESH: rdata = thr_q;
            default:    rdata = '0;
        endcase
    end

    // R5: with the master enable off, the request is low next cycle.
    a_r5_master_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !me_q |=> !irq_out);

    // R6/R9: a request is raised only for an earlier enabled, unmasked source.
    a_r6_req_cause: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> $past(me_q && (|(pend & en_q & thr_mask))));

    // R10: in test mode without an injection write no pending bit appears.
    a_r10_test_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_q && !wr_inj) |=> ((pend & ~$past(pend)) == '0));

    // R10: an injection write in run mode sets no bit that hardware did not.
    a_r10_run_inject: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && wr_inj) |=> ((pend & ~$past(pend) & ~$past(hw_evt)) == '0));
endmodule

// File: tb/irq_ctrl_top_tb.sv
`timescale 1ns/1ps
module irq_ctrl_top_tb;
    localparam int A_RAW = 0, A_ACT = 1, A_EN = 2, A_ACK = 3, A_ESET = 4,
                   A_ECLR = 5, A_VEC = 6, A_CTL = 7, A_THR = 8, A_INJ = 9;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] irq_in = '0;
    logic        cascade_in = 1'b0;
    logic [3:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq_out;
    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    irq_ctrl_top #(
        .NUM_SRC(32), .ADDR_W(4), .ROLE(irq_pkg::ROLE_PRIMARY),
        .EDGE_MASK(32'h0000_FFFF)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .cascade_in(cascade_in),
        .addr(addr), .wr_en(wr_en), .wdata(wdata), .rdata(rdata), .irq_out(irq_out)
    );

    function automatic logic [31:0] f_vec(input logic [31:0] v);
        for (int i = 0; i < 32; i++) if (v[i]) return 32'(i);
        return 32'hFFFF_FFFF;
    endfunction

    function automatic logic [31:0] f_thr(input logic [31:0] n);
        logic [31:0] m = '0;
        for (int i = 0; i < 32; i++) m[i] = (32'(i) < n);
        return m;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        addr = 4'(a); wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        addr = 4'(a);
        #1 d = rdata;
    endtask

    task automatic waitn(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        logic [31:0] d, en, inj, thr;
        void'($urandom(32'd1234));
        waitn(3);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(A_RAW, d); chk("R1 raw", d, 0);
        rd(A_EN, d);  chk("R1 enable", d, 0);
        rd(A_CTL, d); chk("R1 ctrl", d, 0);
        rd(A_THR, d); chk("R1 threshold", d, 32'hFFFF_FFFF);
        rd(A_VEC, d); chk("R1 vector", d, 32'hFFFF_FFFF);
        chk("R1 irq", 32'(irq_out), 0);

        // R4 enable access styles
        wr(A_EN, 32'h0000_00F0);
        rd(A_EN, d); chk("R4 enable write", d, 32'h0000_00F0);
        wr(A_ESET, 32'h0000_0003);
        rd(A_EN, d); chk("R4 enable set", d, 32'h0000_00F3);
        wr(A_ECLR, 32'h0000_0030);
        rd(A_EN, d); chk("R4 enable clear", d, 32'h0000_00C3);

        // R10 test mode: hardware ignored
        wr(A_CTL, 32'h1);
        irq_in = 32'hFFFF_FFFF; cascade_in = 1'b1;
        waitn(6);
        rd(A_RAW, d); chk("R10 hw ignored in test mode", d, 0);
        irq_in = '0; cascade_in = 1'b0;
        waitn(4);
        wr(A_INJ, 32'h0000_0104);
        rd(A_RAW, d); chk("R10 inject", d, 32'h0000_0104);
        rd(A_ACT, d); chk("R4 active word", d, 0);
        rd(A_VEC, d); chk("R2 vector none enabled", d, 32'hFFFF_FFFF);
        @(negedge clk);
        chk("R5 no irq when none enabled", 32'(irq_out), 0);
        wr(A_ACK, 32'h0000_0004);
        rd(A_RAW, d); chk("R3 partial ack", d, 32'h0000_0100);
        wr(A_ACK, 32'hFFFF_FFFF);

        // Random passes: R2, R4, R9
        for (int k = 0; k < 24; k++) begin
            en  = $urandom();
            inj = $urandom();
            thr = (k % 4 == 0) ? 32'($urandom_range(0, 40)) : 32'($urandom_range(0, 32));
            if (k % 3 == 0) inj = inj & en;
            wr(A_EN, en);
            wr(A_THR, thr);
            wr(A_INJ, inj);
            rd(A_RAW, d); chk("R10 random inject", d, inj);
            rd(A_ACT, d); chk("R4 random active", d, inj & en);
            rd(A_VEC, d); chk("R2 random vector", d, f_vec(inj & en));
            @(negedge clk);
            chk("R9 random threshold irq", 32'(irq_out), 32'(|(inj & en & f_thr(thr))));
            wr(A_ACK, 32'hFFFF_FFFF);
            rd(A_RAW, d); chk("R3 ack all", d, 0);
        end
        wr(A_THR, 32'hFFFF_FFFF);
        wr(A_EN, 32'hFFFF_FFFF);
        @(negedge clk);

        // R6 request latency
        wr(A_INJ, 32'h1);
        rd(A_RAW, d); chk("R6 pending first", d, 32'h1);
        chk("R6 irq not yet", 32'(irq_out), 0);
        @(negedge clk);
        chk("R6 irq one clock later", 32'(irq_out), 1);
        wr(A_ACK, 32'h1);

        // R5 master enable
        wr(A_CTL, 32'h0);
        wr(A_INJ, 32'h2);
        waitn(2);
        chk("R5 master off", 32'(irq_out), 0);
        wr(A_CTL, 32'h1);
        @(negedge clk);
        chk("R5 master on", 32'(irq_out), 1);
        wr(A_ACK, 32'h2);

        // R10 run mode: injection has no effect
        wr(A_CTL, 32'h3);
        wr(A_INJ, 32'h0000_0002);
        rd(A_RAW, d); chk("R10 inject ignored in run mode", d, 0);
        waitn(2);
        chk("R10 no irq from ignored inject", 32'(irq_out), 0);

        // R7 edge line 3, with R6 synchronizer latency
        @(negedge clk); irq_in[3] = 1'b1;
        waitn(2);
        rd(A_RAW, d); chk("R6 not pending after two edges", d, 0);
        @(negedge clk);
        rd(A_RAW, d); chk("R6 pending after three edges", d, 32'h8);
        chk("R6 irq lags pending", 32'(irq_out), 0);
        @(negedge clk);
        chk("R6 irq raised", 32'(irq_out), 1);
        irq_in[3] = 1'b0;
        waitn(4);
        rd(A_RAW, d); chk("R7 edge held after fall", d, 32'h8);
        wr(A_ACK, 32'h8);
        rd(A_RAW, d); chk("R7 edge cleared", d, 0);
        @(negedge clk); irq_in[3] = 1'b1;
        @(negedge clk); irq_in[3] = 1'b0;
        waitn(4);
        rd(A_RAW, d); chk("R7 new edge after ack", d, 32'h8);
        wr(A_ACK, 32'h8);
        irq_in[3] = 1'b1;
        waitn(6);
        wr(A_ACK, 32'h8);
        waitn(3);
        rd(A_RAW, d); chk("R7 steady high no new edge", d, 0);
        irq_in[3] = 1'b0;

        // R8 level line 20
        irq_in[20] = 1'b1;
        waitn(4);
        rd(A_RAW, d); chk("R8 level pending", d, 32'h0010_0000);
        wr(A_ACK, 32'h0010_0000);
        rd(A_RAW, d); chk("R8 ack while high stays", d, 32'h0010_0000);
        irq_in[20] = 1'b0;
        waitn(4);
        wr(A_ACK, 32'h0010_0000);
        waitn(3);
        rd(A_RAW, d); chk("R8 cleared once low", d, 0);

        // R9 threshold with hardware pending bit 5
        wr(A_THR, 32'd5);
        @(negedge clk); irq_in[5] = 1'b1;
        @(negedge clk); irq_in[5] = 1'b0;
        waitn(5);
        rd(A_RAW, d); chk("R9 pending recorded", d, 32'h20);
        chk("R9 masked at threshold", 32'(irq_out), 0);
        wr(A_THR, 32'd6);
        @(negedge clk);
        chk("R9 passes above threshold", 32'(irq_out), 1);
        wr(A_THR, 32'hFFFF_FFFF);

        // R2 vector with two hardware sources
        @(negedge clk); irq_in[9] = 1'b1; irq_in[4] = 1'b1;
        @(negedge clk); irq_in[9] = 1'b0; irq_in[4] = 1'b0;
        waitn(4);
        rd(A_VEC, d); chk("R2 vector lowest", d, 32'd4);
        wr(A_ECLR, 32'h10);
        rd(A_VEC, d); chk("R2 vector skips disabled", d, 32'd5);
        wr(A_ESET, 32'h10);
        wr(A_ACK, 32'hFFFF_FFFF);

        // R11 chain link on line 31
        irq_in[31] = 1'b1;
        waitn(6);
        rd(A_RAW, d); chk("R11 irq_in31 ignored", d, 0);
        irq_in[31] = 1'b0;
        @(negedge clk); cascade_in = 1'b1;
        waitn(3);
        rd(A_RAW, d); chk("R11 cascade pending", d, 32'h8000_0000);
        rd(A_VEC, d); chk("R11 cascade vector", d, 32'd31);
        wr(A_ACK, 32'h8000_0000);
        rd(A_RAW, d); chk("R11 cascade level across ack", d, 32'h8000_0000);
        cascade_in = 1'b0;
        waitn(4);
        wr(A_ACK, 32'h8000_0000);
        waitn(2);
        rd(A_RAW, d); chk("R11 cascade cleared", d, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule